// File: doc/BRIEF.md
# Video DMA Engine

The engine copies bytes from anywhere in a 16-bit address space into a fixed 8 KB video memory window that starts at 0x8000. Software sets it up through five byte-wide registers: a source address split into high and low bytes, a destination address split the same way, and a control register that holds the length and selects the mode. The source and destination are both forced to 16-byte alignment. The destination is also confined to the window, so it wraps inside the window rather than leaving it.

There are two modes. A general transfer copies the whole requested length as soon as the control register is written. A blanking transfer copies one 16-byte chunk each time the display enters its horizontal-blank state, which is display mode 0. While a blanking transfer runs, the control register gives the number of chunks still to copy, minus one. The transfer can be cancelled or restarted by writing the control register again.

The engine drives a byte-wide memory master with separate read and write strobes. The memory is assumed to return read data one cycle after a read. While the engine owns the bus, `busy_o` is high. The system uses that signal to hold off other masters.

Top module: `vdma_top`

## Requirements
- R1: After reset, index 4 (control) reads 0xFF and indices 0 to 3 read 0x00. `busy_o`, `mem_re_o` and `mem_we_o` are all low.
- R2: Index 0 is the source high byte and index 1 is the source low byte. The first read address is high*256 + (low & 0xF0), so the low four bits are ignored, and index 1 reads back low & 0xF0. Each later read address is the previous one plus 1, wrapping at 16 bits.
- R3: Index 2 is the destination high byte and index 3 is the destination low byte. The first write address is 0x8000 | (high & 0x1F)<<8 | (low & 0xF0). Index 2 reads back high & 0x1F. Write addresses advance by 1 and wrap inside 0x8000 to 0x9FFF.
- R4: A write to index 4 with bit 7 = 0 while no blanking transfer is active starts a general transfer of (bits 6:0 + 1) * 16 bytes. Source byte k is copied to destination byte k. Index 4 reads 0xFF from the next cycle on.
- R5: A write to index 4 with bit 7 = 1 makes blanking mode active, and index 4 then reads the written value & 0x7F. Nothing is copied until a mode-0 entry, except when `disp_mode_i` is 0 in the write cycle; in that case one 16-byte chunk starts at once.
- R6: While blanking mode is active, each change of `disp_mode_i` from a nonzero value to 0 copies exactly 16 bytes. Staying in mode 0 copies nothing more.
- R7: After each 16-byte chunk, in either mode, indices 0 to 3 read the addresses advanced by 16, with the destination masked as in R3. In blanking mode, index 4 also decreases by one.
- R8: If a blanking chunk is copied while index 4 reads 0x00, index 4 reads 0xFF afterwards and blanking mode ends. Later mode-0 entries then copy nothing.
- R9: A write to index 4 with bit 7 = 0 while blanking mode is active cancels it. No general copy happens, index 4 reads the value & 0x7F, and later mode-0 entries copy nothing. A write with bit 7 = 1 while blanking mode is active reloads the count.
- R10: A read issued with `mem_re_o` is written one cycle later with `mem_we_o`, using `mem_rdata_i`. One byte moves per cycle. `busy_o` is high from the cycle after the start through the cycle of the last write, which is L+1 cycles for L bytes.
- R11: Register writes made while `busy_o` is high are ignored, for every index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register index: 0 source high, 1 source low, 2 destination high, 3 destination low, 4 control |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for `reg_addr_i` (combinational) |
| disp_mode_i | input | 2 | Display mode; 0 is horizontal blank |
| mem_re_o | output | 1 | Memory read strobe |
| mem_raddr_o | output | 16 | Memory read address |
| mem_rdata_i | input | 8 | Read data, valid one cycle after `mem_re_o` |
| mem_we_o | output | 1 | Memory write strobe |
| mem_waddr_o | output | 16 | Memory write address, always inside 0x8000 to 0x9FFF |
| mem_wdata_o | output | 8 | Memory write data |
| busy_o | output | 1 | Engine owns the memory bus |

## Verification
A start is registered at the clock edge that takes the control write, or at the edge that sees the mode-0 entry. The first read is therefore visible in the cycle after that edge, and its write follows one cycle later. The address registers and the control register change at the edge of each chunk's sixteenth write, and `busy_o` stays high for L+1 cycles. The bench drives inputs and samples outputs at falling edges. It checks the first read and first write in exactly those cycles, and it counts the busy cycles one by one. The final register values are read only after `busy_o` has fallen.

// File: rtl/vdma_pkg.sv
package vdma_pkg;
  localparam int unsigned ADDR_W   = 16;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned CHUNK_LG = 4;   // 16-byte chunks
  localparam int unsigned WIN_LG   = 13;  // 8 KB destination window
  localparam int unsigned CNT_W    = 7;   // chunk count field
  localparam logic [ADDR_W-1:0] WIN_BASE = 16'h8000;
  localparam logic [1:0] MODE_HBLANK = 2'd0;

  typedef enum logic [2:0] {
    RA_SRC_HI = 3'd0,
    RA_SRC_LO = 3'd1,
    RA_DST_HI = 3'd2,
    RA_DST_LO = 3'd3,
    RA_CTRL   = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/vdma_addr_regs.sv
module vdma_addr_regs
  import vdma_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [2:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              chunk_done_i,
  output logic [ADDR_W-1:0] src_o,
  output logic [WIN_LG-1:0] dst_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned SRC_BLK_W = ADDR_W - CHUNK_LG;
  localparam int unsigned DST_BLK_W = WIN_LG - CHUNK_LG;
  localparam int unsigned LO_W      = DATA_W - CHUNK_LG;
  localparam int unsigned DHI_W     = DST_BLK_W - LO_W;

  logic [SRC_BLK_W-1:0] src_blk_q;
  logic [DST_BLK_W-1:0] dst_blk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_blk_q <= '0;
      dst_blk_q <= '0;
    end else if (wr_en_i) begin
      unique case (addr_i)
        RA_SRC_HI: src_blk_q[SRC_BLK_W-1:LO_W] <= wdata_i;
        RA_SRC_LO: src_blk_q[LO_W-1:0]         <= wdata_i[DATA_W-1:CHUNK_LG];
        RA_DST_HI: dst_blk_q[DST_BLK_W-1:LO_W] <= wdata_i[DHI_W-1:0];
        RA_DST_LO: dst_blk_q[LO_W-1:0]         <= wdata_i[DATA_W-1:CHUNK_LG];
        default: ;
      endcase
    end else if (chunk_done_i) begin
      // write back advanced addresses, one chunk at a time
      src_blk_q <= src_blk_q + 1'b1;
      dst_blk_q <= dst_blk_q + 1'b1;
    end
  end

  assign src_o = {src_blk_q, {CHUNK_LG{1'b0}}};
  assign dst_o = {dst_blk_q, {CHUNK_LG{1'b0}}};

  always_comb begin
    unique case (addr_i)
      RA_SRC_HI: rdata_o = src_blk_q[SRC_BLK_W-1:LO_W];
      RA_SRC_LO: rdata_o = {src_blk_q[LO_W-1:0], {CHUNK_LG{1'b0}}};
      RA_DST_HI: rdata_o = DATA_W'(dst_blk_q[DST_BLK_W-1:LO_W]);
      RA_DST_LO: rdata_o = {dst_blk_q[LO_W-1:0], {CHUNK_LG{1'b0}}};
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/vdma_ctrl.sv
module vdma_ctrl
  import vdma_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  input  logic [1:0]        disp_mode_i,
  input  logic              busy_i,
  input  logic              chunk_done_i,
  output logic              addr_we_o,
  output logic              launch_o,
  output logic [CNT_W:0]    nchunks_o,
  output logic [DATA_W-1:0] ctrl_o
);
  logic [1:0]        mode_q;
  logic              active_q;
  logic [DATA_W-1:0] ctrl_q;
  logic wr_ctrl, sel_hb, gen_go, hb_start, hb_edge, hb_entry;

  assign addr_we_o = reg_we_i && !busy_i && (reg_addr_i != RA_CTRL);
  assign wr_ctrl   = reg_we_i && !busy_i && (reg_addr_i == RA_CTRL);
  assign sel_hb    = reg_wdata_i[DATA_W-1];
  assign hb_entry  = (disp_mode_i == MODE_HBLANK) && (mode_q != MODE_HBLANK);

  assign gen_go   = wr_ctrl && !sel_hb && !active_q;
  assign hb_start = wr_ctrl && sel_hb && (disp_mode_i == MODE_HBLANK);
  // a control write in the same cycle takes precedence over the mode edge
  assign hb_edge  = active_q && !wr_ctrl && !busy_i && hb_entry;

  assign launch_o  = gen_go || hb_start || hb_edge;
  assign nchunks_o = gen_go ? ({1'b0, reg_wdata_i[CNT_W-1:0]} + 1'b1)
                            : (CNT_W+1)'(1);
  assign ctrl_o    = ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= MODE_HBLANK;
      active_q <= 1'b0;
      ctrl_q   <= '1;
    end else begin
      mode_q <= disp_mode_i;
      if (wr_ctrl) begin
        if (active_q || sel_hb) begin
          active_q <= sel_hb;
          ctrl_q   <= {1'b0, reg_wdata_i[CNT_W-1:0]};
        end else begin
          ctrl_q <= '1;
        end
      end else if (chunk_done_i && active_q) begin
        if (ctrl_q[CNT_W-1:0] == '0) active_q <= 1'b0;
        ctrl_q <= ctrl_q - 1'b1;  // 0x00 wraps to 0xFF: idle
      end
    end
  end
endmodule

// File: rtl/vdma_mover.sv
module vdma_mover
  import vdma_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              launch_i,
  input  logic [CNT_W:0]    nchunks_i,
  input  logic [ADDR_W-1:0] src_i,
  input  logic [WIN_LG-1:0] dst_i,
  output logic              re_o,
  output logic [ADDR_W-1:0] raddr_o,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              we_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              chunk_done_o,
  output logic              busy_o
);
  localparam int unsigned LEFT_W = CNT_W + CHUNK_LG + 1;

  logic [LEFT_W-1:0] rd_left_q;
  logic [ADDR_W-1:0] rd_ptr_q;
  logic [WIN_LG-1:0] wr_ptr_q;
  logic [WIN_LG-1:0] wr_addr_q;
  logic              wr_pend_q;

  assign re_o    = (rd_left_q != '0);
  assign raddr_o = rd_ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_left_q <= '0;
      rd_ptr_q  <= '0;
      wr_ptr_q  <= '0;
      wr_addr_q <= '0;
      wr_pend_q <= 1'b0;
    end else begin
      if (launch_i) begin
        rd_left_q <= LEFT_W'(nchunks_i) << CHUNK_LG;
        rd_ptr_q  <= src_i;
        wr_ptr_q  <= dst_i;
      end else if (re_o) begin
        rd_left_q <= rd_left_q - 1'b1;
        rd_ptr_q  <= rd_ptr_q + 1'b1;
        wr_ptr_q  <= wr_ptr_q + 1'b1;
      end
      wr_pend_q <= re_o;
      if (re_o) wr_addr_q <= wr_ptr_q;
    end
  end

  assign we_o         = wr_pend_q;
  assign waddr_o      = WIN_BASE | {{(ADDR_W-WIN_LG){1'b0}}, wr_addr_q};
  assign wdata_o      = rdata_i;
  assign chunk_done_o = wr_pend_q && (&wr_addr_q[CHUNK_LG-1:0]);
  assign busy_o       = re_o || wr_pend_q;
endmodule

// File: rtl/vdma_top.sv
module vdma_top
  import vdma_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic [1:0]        disp_mode_i,
  output logic              mem_re_o,
  output logic [ADDR_W-1:0] mem_raddr_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_waddr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              busy_o
);
  logic              addr_we, launch, chunk_done;
  logic [CNT_W:0]    nchunks;
  logic [ADDR_W-1:0] src;
  logic [WIN_LG-1:0] dst;
  logic [DATA_W-1:0] addr_rdata, ctrl_val;

  vdma_ctrl i_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .reg_we_i     (reg_we_i),
    .reg_addr_i   (reg_addr_i),
    .reg_wdata_i  (reg_wdata_i),
    .disp_mode_i  (disp_mode_i),
    .busy_i       (busy_o),
    .chunk_done_i (chunk_done),
    .addr_we_o    (addr_we),
    .launch_o     (launch),
    .nchunks_o    (nchunks),
    .ctrl_o       (ctrl_val)
  );

  vdma_addr_regs i_addr_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (addr_we),
    .addr_i       (reg_addr_i),
    .wdata_i      (reg_wdata_i),
    .chunk_done_i (chunk_done),
    .src_o        (src),
    .dst_o        (dst),
    .rdata_o      (addr_rdata)
  );

  vdma_mover i_mover (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .launch_i     (launch),
    .nchunks_i    (nchunks),
    .src_i        (src),
    .dst_i        (dst),
    .re_o         (mem_re_o),
    .raddr_o      (mem_raddr_o),
    .rdata_i      (mem_rdata_i),
    .we_o         (mem_we_o),
    .waddr_o      (mem_waddr_o),
    .wdata_o      (mem_wdata_o),
    .chunk_done_o (chunk_done),
    .busy_o       (busy_o)
  );

  assign reg_rdata_o = (reg_addr_i == RA_CTRL) ? ctrl_val : addr_rdata;
endmodule

// File: rtl/vdma_checker.sv
module vdma_checker
  import vdma_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mem_re_o,
  input logic [ADDR_W-1:0] mem_raddr_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_waddr_o,
  input logic              busy_o
);
  assert_strobe_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_re_o || mem_we_o) |-> busy_o);

  assert_read_then_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o |=> mem_we_o);

  assert_write_has_read_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> $past(mem_re_o));

  assert_src_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_re_o && $past(mem_re_o)) |-> (mem_raddr_o == $past(mem_raddr_o) + 16'd1));

  assert_src_align_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_re_o && !$past(mem_re_o)) |-> (mem_raddr_o[CHUNK_LG-1:0] == '0));

  assert_dst_window_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (mem_waddr_o[ADDR_W-1:WIN_LG] == WIN_BASE[ADDR_W-1:WIN_LG]));

  assert_dst_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && $past(mem_we_o)) |->
      (mem_waddr_o[WIN_LG-1:0] == $past(mem_waddr_o[WIN_LG-1:0]) + 1'b1));
endmodule

bind vdma_top vdma_checker i_vdma_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mem_re_o    (mem_re_o),
  .mem_raddr_o (mem_raddr_o),
  .mem_we_o    (mem_we_o),
  .mem_waddr_o (mem_waddr_o),
  .busy_o      (busy_o)
);

// File: tb/test_vdma_top.sv
module test_vdma_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [7:0]  reg_wdata = 8'h00;
  logic [7:0]  reg_rdata;
  logic [1:0]  disp_mode = 2'd2;
  logic        mem_re, mem_we, busy;
  logic [15:0] mem_raddr, mem_waddr;
  logic [7:0]  mem_rdata = 8'h00;
  logic [7:0]  mem_wdata;

  int total = 0;
  int bad = 0;
  int wr_cnt = 0;
  int wr_err = 0;
  logic [15:0] exp_src = '0;
  logic [12:0] exp_dst = '0;

  always #2 clk = ~clk;  // 250 MHz

  vdma_top i_vdma_top (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .disp_mode_i(disp_mode),
    .mem_re_o(mem_re), .mem_raddr_o(mem_raddr), .mem_rdata_i(mem_rdata),
    .mem_we_o(mem_we), .mem_waddr_o(mem_waddr), .mem_wdata_o(mem_wdata),
    .busy_o(busy)
  );

  function automatic logic [7:0] src_byte(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
  endfunction

  // source memory model: one-cycle read latency
  always @(posedge clk) if (mem_re) mem_rdata <= src_byte(mem_raddr);

  // destination monitor: byte k of the run must land at dst+k with src byte k
  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      logic [15:0] ea;
      ea = 16'h8000 | {3'b000, exp_dst + 13'(wr_cnt)};
      if (mem_waddr !== ea || mem_wdata !== src_byte(exp_src + 16'(wr_cnt))) wr_err++;
      wr_cnt++;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk);
    disp_mode = m;
    @(negedge clk);
    wait_idle();
  endtask

  task automatic program_addr(input logic [7:0] sh, sl, dh, dl);
    reg_wr(3'd0, sh); reg_wr(3'd1, sl); reg_wr(3'd2, dh); reg_wr(3'd3, dl);
  endtask

  task automatic test_reset();
    logic [7:0] d;
    reg_rd(3'd4, d); check("R1 control after reset", d, 8'hFF);
    reg_rd(3'd0, d); check("R1 source high after reset", d, 8'h00);
    reg_rd(3'd3, d); check("R1 dest low after reset", d, 8'h00);
    check("R1 busy after reset", busy, 1'b0);
    check("R1 strobes after reset", {mem_re, mem_we}, 2'b00);
  endtask

  task automatic test_general();
    logic [7:0] d;
    int n;
    program_addr(8'h12, 8'h34, 8'hE3, 8'h47);
    reg_rd(3'd1, d); check("R2 source low readback", d, 8'h30);
    reg_rd(3'd2, d); check("R3 dest high readback", d, 8'h03);
    reg_rd(3'd3, d); check("R3 dest low readback", d, 8'h40);
    exp_src = 16'h1230; exp_dst = 13'h0340; wr_cnt = 0; wr_err = 0;
    reg_wr(3'd4, 8'h02);
    check("R10 first read cycle", mem_re, 1'b1);
    check("R2 first read address", mem_raddr, 16'h1230);
    reg_rd(3'd4, d); check("R4 control reads idle at once", d, 8'hFF);
    n = 1;
    @(negedge clk);
    check("R10 first write cycle", mem_we, 1'b1);
    check("R3 first write address", mem_waddr, 16'h8340);
    while (busy && n < 5000) begin
      n++;
      @(negedge clk);
    end
    check("R10 busy length", n, 49);
    check("R4 general byte count", wr_cnt, 48);
    check("R4 general data and addresses", wr_err, 0);
    reg_rd(3'd0, d); check("R7 source high writeback", d, 8'h12);
    reg_rd(3'd1, d); check("R7 source low writeback", d, 8'h60);
    reg_rd(3'd2, d); check("R7 dest high writeback", d, 8'h03);
    reg_rd(3'd3, d); check("R7 dest low writeback", d, 8'h70);
  endtask

  task automatic test_wrap();
    logic [7:0] d;
    program_addr(8'hAB, 8'h0F, 8'hFF, 8'hF9);
    exp_src = 16'hAB00; exp_dst = 13'h1FF0; wr_cnt = 0; wr_err = 0;
    reg_wr(3'd4, 8'h01);
    wait_idle();
    check("R3 window wrap byte count", wr_cnt, 32);
    check("R3 window wrap addresses", wr_err, 0);
    reg_rd(3'd2, d); check("R7 dest high after wrap", d, 8'h00);
    reg_rd(3'd3, d); check("R7 dest low after wrap", d, 8'h10);
    reg_rd(3'd1, d); check("R7 source low after wrap test", d, 8'h20);
  endtask

  task automatic test_hblank();
    logic [7:0] d;
    set_mode(2'd2);
    program_addr(8'h40, 8'h00, 8'h01, 8'h00);
    exp_src = 16'h4000; exp_dst = 13'h0100; wr_cnt = 0; wr_err = 0;
    reg_wr(3'd4, 8'h82);
    reg_rd(3'd4, d); check("R5 blanking start readback", d, 8'h02);
    repeat (10) @(negedge clk);
    check("R5 no copy before entry", wr_cnt, 0);
    set_mode(2'd0);
    check("R6 one chunk per entry", wr_cnt, 16);
    reg_rd(3'd4, d); check("R7 count decrement", d, 8'h01);
    reg_rd(3'd1, d); check("R7 source low after chunk", d, 8'h10);
    repeat (30) @(negedge clk);
    check("R6 staying in mode 0 copies nothing", wr_cnt, 16);
    set_mode(2'd3); set_mode(2'd0);
    check("R6 second entry", wr_cnt, 32);
    reg_rd(3'd4, d); check("R7 count reaches zero", d, 8'h00);
    set_mode(2'd1); set_mode(2'd0);
    check("R8 final chunk", wr_cnt, 48);
    reg_rd(3'd4, d); check("R8 control idle after end", d, 8'hFF);
    set_mode(2'd2); set_mode(2'd0);
    check("R8 no copy after end", wr_cnt, 48);
    check("R6 blanking data and addresses", wr_err, 0);
  endtask

  task automatic test_immediate();
    logic [7:0] d;
    set_mode(2'd0);
    program_addr(8'h50, 8'h00, 8'h02, 8'h00);
    exp_src = 16'h5000; exp_dst = 13'h0200; wr_cnt = 0; wr_err = 0;
    reg_wr(3'd4, 8'h81);
    check("R5 immediate chunk when in mode 0", mem_re, 1'b1);
    wait_idle();
    check("R5 immediate chunk size", wr_cnt, 16);
    reg_rd(3'd4, d); check("R5 count after immediate chunk", d, 8'h00);
    set_mode(2'd1); set_mode(2'd0);
    check("R8 last chunk after immediate", wr_cnt, 32);
    reg_rd(3'd4, d); check("R8 idle after immediate run", d, 8'hFF);
    check("R5 immediate data", wr_err, 0);
  endtask

  task automatic test_cancel();
    logic [7:0] d;
    set_mode(2'd2);
    program_addr(8'h60, 8'h00, 8'h03, 8'h00);
    exp_src = 16'h6000; exp_dst = 13'h0300; wr_cnt = 0; wr_err = 0;
    reg_wr(3'd4, 8'h85);
    set_mode(2'd0);
    reg_rd(3'd4, d); check("R9 count before cancel", d, 8'h04);
    set_mode(2'd2);
    reg_wr(3'd4, 8'h03);
    reg_rd(3'd4, d); check("R9 cancel readback", d, 8'h03);
    repeat (20) @(negedge clk);
    check("R9 cancel starts no general copy", wr_cnt, 16);
    set_mode(2'd0);
    check("R9 no copy after cancel", wr_cnt, 16);
    set_mode(2'd2);
    reg_wr(3'd4, 8'h85);
    reg_wr(3'd4, 8'h81);
    reg_rd(3'd4, d); check("R9 restart reloads count", d, 8'h01);
    set_mode(2'd0);
    check("R9 chunk after restart", wr_cnt, 32);
    set_mode(2'd2); set_mode(2'd0);
    check("R9 restarted run ends", wr_cnt, 48);
    reg_rd(3'd4, d); check("R9 idle after restarted run", d, 8'hFF);
    check("R9 cancel data", wr_err, 0);
  endtask

  task automatic test_busy_ignore();
    logic [7:0] d;
    set_mode(2'd2);
    program_addr(8'h20, 8'h00, 8'h04, 8'h00);
    exp_src = 16'h2000; exp_dst = 13'h0400; wr_cnt = 0; wr_err = 0;
    reg_wr(3'd4, 8'h0F);
    repeat (5) @(negedge clk);
    reg_wr(3'd0, 8'h77);
    reg_wr(3'd4, 8'h80);
    wait_idle();
    check("R11 transfer unaffected count", wr_cnt, 256);
    check("R11 transfer unaffected data", wr_err, 0);
    reg_rd(3'd0, d); check("R11 source write ignored", d, 8'h21);
    reg_rd(3'd4, d); check("R11 control write ignored", d, 8'hFF);
    set_mode(2'd0);
    check("R11 ignored blanking start copies nothing", wr_cnt, 256);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R10 actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_general();
    test_wrap();
    test_hblank();
    test_immediate();
    test_cancel();
    test_busy_ignore();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule